// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable device-side model of a small nonvolatile memory reached over a three-wire serial link. A host raises chip select, clocks instruction bits in on the serial data input, and reads results or status on a data output that is only driven while chip select is high. All serial inputs are sampled by a fast system clock. The serial clock is treated as a slow data signal, and its rising edges are found by comparing it with its value on the previous system clock.

The memory holds 128 bytes by default. An organization input selects how they are seen: as 64 words of 16 bits or as 128 words of 8 bits. Reads return a zero dummy bit and then a continuous stream of words, and the address wraps at the top of the array. Writes, erases and their whole-array forms are gated by an enable latch. They begin only when a complete frame is closed by chip select falling, and then run for a fixed number of system clocks. While they run the output shows busy or ready status.

Top module: `mw_eeprom`

## Requirements
- R1: With chip select high, bits are taken on serial clock rising edges. Zeros before the first 1 are skipped. That first 1 is the start bit. It is followed by a 2-bit opcode, then the address MSB first (6 bits when org16=1, 7 bits when org16=0), then for write commands the data MSB first (16 or 8 bits).
- R2: The opcode selects the command: 10 read, 01 write, 11 erase. Opcode 00 is a special group chosen by the top two address bits: 11 enable, 00 disable, 10 erase-all, 01 write-all (write-all carries a data field).
- R3: The program-enable latch is clear after reset. While it is clear, write, erase, write-all and erase-all change nothing and start no cycle. Enable sets the latch and disable clears it, each at its last address bit. Reads do not depend on the latch.
- R4: At the rising edge that carries the last address bit of a read, the output shows a 0 dummy bit. Each following rising edge shows the next data bit, MSB first.
- R5: After the last bit of a word, the next rising edge shows the MSB of the word at address+1. The address wraps from the top word to word 0, and the stream runs until chip select falls.
- R6: A program cycle starts on the system clock after chip select falls, and only if the frame had every address bit (and every data bit, for writes), the latch is set, and no cycle is running. It keeps the device busy for PROG_CYCLES system clocks.
- R7: From the start of a program cycle until the next start bit, so_en is 1 whenever chip select is high. so_data is then 0 while busy and 1 once ready.
- R8: Erase and erase-all set their words to all ones. Write and write-all store exactly the data given.
- R9: Serial bits that arrive while a program cycle runs are ignored entirely, including enable and disable.
- R10: All bytes are 8'hFF after reset. A 16-bit word a is byte 2a (upper half) and byte 2a+1 (lower half). An 8-bit address selects a byte directly.
- R11: so_en is 0 whenever chip select is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock, sampled by clk |
| di | input | 1 | Serial data in |
| org16 | input | 1 | 1 = 16-bit words, 0 = 8-bit words |
| so_data | output | 1 | Serial data out value |
| so_en | output | 1 | Output drive enable (0 = high impedance) |

## Verification
Several rules are checked on every cycle by the assertions. A program cycle starts only with the latch set, only on the cycle after chip select falls, and never while one is already running. Busy follows each start. The latch is clear after reset. A read stream always begins with a zero. The data contents cannot be shown by a property: values that survive writes, erases, whole-array commands and wraparound, the byte mapping between the two organizations, and the effect of ignored or short frames. Those come out only through the bench's scenarios, checked against its behavioural model on every clock.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [1:0] {
        OP_SPECIAL = 2'b00,
        OP_WRITE   = 2'b01,
        OP_READ    = 2'b10,
        OP_ERASE   = 2'b11
    } opcode_e;

    typedef enum logic [1:0] {
        SUB_DISABLE   = 2'b00,
        SUB_WRITE_ALL = 2'b01,
        SUB_ERASE_ALL = 2'b10,
        SUB_ENABLE    = 2'b11
    } special_e;

    typedef enum logic [1:0] {
        PK_WRITE,
        PK_ERASE,
        PK_WRITE_ALL,
        PK_ERASE_ALL
    } prog_kind_e;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_OPCODE,
        FS_ADDR,
        FS_DATA,
        FS_STREAM,
        FS_DONE
    } frame_state_e;

    function automatic logic [4:0] addr_len(input logic org16, input int waw);
        return org16 ? 5'(waw) : 5'(waw + 1);
    endfunction

    function automatic logic [4:0] data_len(input logic org16);
        return org16 ? 5'd16 : 5'd8;
    endfunction

endpackage

// File: rtl/mw_edge_sense.sv
module mw_edge_sense (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sk,
    output logic sk_rise,
    output logic cs_fall
);
    logic sk_q;
    logic cs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sk_q <= 1'b0;
            cs_q <= 1'b0;
        end else begin
            sk_q <= sk;
            cs_q <= cs;
        end
    end

    assign sk_rise = sk & ~sk_q;
    assign cs_fall = ~cs & cs_q;
endmodule

// File: rtl/mw_prog_timer.sv
module mw_prog_timer #(
    parameter int CYCLES = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic busy
);
    localparam int TW = $clog2(CYCLES + 1);
    logic [TW-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (go)
            remain <= TW'(CYCLES);
        else if (remain != '0)
            remain <= remain - TW'(1);
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/mw_cell_array.sv
module mw_cell_array
    import mw_pkg::*;
#(
    parameter int BAW = 7
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           org16,
    input  logic           prog_go,
    input  prog_kind_e     prog_kind,
    input  logic [BAW-1:0] prog_addr,
    input  logic [15:0]    prog_data,
    input  logic [BAW-1:0] rd_addr,
    output logic [15:0]    rd_word
);
    localparam int NBYTES = 2 ** BAW;

    logic [NBYTES*8-1:0] flat;
    logic                bulk;
    logic                erasing;

    assign bulk    = (prog_kind == PK_WRITE_ALL) || (prog_kind == PK_ERASE_ALL);
    assign erasing = (prog_kind == PK_ERASE) || (prog_kind == PK_ERASE_ALL);

    for (genvar i = 0; i < NBYTES; i++) begin : g_cell
        localparam logic [BAW-1:0] IDX = BAW'(i);
        logic [7:0] q;
        logic       hit;
        logic [7:0] val;

        assign hit = bulk || (org16 ? (IDX[BAW-1:1] == prog_addr[BAW-2:0])
                                    : (IDX == prog_addr));
        assign val = erasing ? 8'hFF
                   : (org16 ? (IDX[0] ? prog_data[7:0] : prog_data[15:8])
                            : prog_data[7:0]);

        always_ff @(posedge clk) begin
            if (rst)
                q <= 8'hFF;
            else if (prog_go && hit)
                q <= val;
        end

        assign flat[i*8 +: 8] = q;
    end

    logic [BAW-1:0] hi_idx;
    logic [BAW-1:0] lo_idx;
    assign hi_idx = {rd_addr[BAW-2:0], 1'b0};
    assign lo_idx = {rd_addr[BAW-2:0], 1'b1};

    always_comb begin
        if (org16)
            rd_word = {flat[hi_idx*8 +: 8], flat[lo_idx*8 +: 8]};
        else
            rd_word = {flat[rd_addr*8 +: 8], 8'h00};
    end
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom
    import mw_pkg::*;
#(
    parameter int WAW         = 6,
    parameter int PROG_CYCLES = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic cs,
    input  logic sk,
    input  logic di,
    input  logic org16,
    output logic so_data,
    output logic so_en
);
    localparam int BAW = WAW + 1;

    logic           sk_rise, cs_fall;
    frame_state_e   st;
    logic [1:0]     op_sh;
    logic [BAW-1:0] addr_sh, addr_nx, rd_addr, rd_inc, rd_next, fetch_addr;
    logic [15:0]    data_sh, rd_sh, rd_word;
    logic [4:0]     cnt, rbit, alen, dlen;
    logic           wen_q, show_q, out_bit, reading;
    logic           busy, prog_go, pend_valid;
    prog_kind_e     pend_kind;
    special_e       sub;

    mw_edge_sense u_edge (
        .clk(clk), .rst(rst), .cs(cs), .sk(sk),
        .sk_rise(sk_rise), .cs_fall(cs_fall)
    );

    mw_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst(rst), .go(prog_go), .busy(busy)
    );

    mw_cell_array #(.BAW(BAW)) u_cells (
        .clk(clk), .rst(rst), .org16(org16),
        .prog_go(prog_go), .prog_kind(pend_kind),
        .prog_addr(addr_sh), .prog_data(data_sh),
        .rd_addr(fetch_addr), .rd_word(rd_word)
    );

    assign alen    = addr_len(org16, WAW);
    assign dlen    = data_len(org16);
    assign addr_nx = {addr_sh[BAW-2:0], di};
    assign sub     = special_e'(org16 ? addr_nx[WAW-1 -: 2] : addr_nx[BAW-1 -: 2]);
    assign rd_inc  = rd_addr + BAW'(1);
    assign rd_next = org16 ? {1'b0, rd_inc[BAW-2:0]} : rd_inc;
    assign fetch_addr = (st == FS_ADDR) ? addr_nx : rd_next;

    assign prog_go = cs_fall && (st == FS_DONE) && pend_valid && wen_q && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= FS_IDLE;
            op_sh      <= '0;
            addr_sh    <= '0;
            data_sh    <= '0;
            cnt        <= '0;
            wen_q      <= 1'b0;
            show_q     <= 1'b0;
            reading    <= 1'b0;
            out_bit    <= 1'b0;
            rd_addr    <= '0;
            rd_sh      <= '0;
            rbit       <= '0;
            pend_valid <= 1'b0;
            pend_kind  <= PK_WRITE;
        end else if (!cs) begin
            st         <= FS_IDLE;
            reading    <= 1'b0;
            pend_valid <= 1'b0;
            if (prog_go)
                show_q <= 1'b1;
        end else if (sk_rise && !busy) begin
            unique case (st)
                FS_IDLE: if (di) begin
                    st      <= FS_OPCODE;
                    cnt     <= '0;
                    op_sh   <= '0;
                    addr_sh <= '0;
                    data_sh <= '0;
                    show_q  <= 1'b0;
                end
                FS_OPCODE: begin
                    op_sh <= {op_sh[0], di};
                    cnt   <= cnt + 5'd1;
                    if (cnt == 5'd1) begin
                        st  <= FS_ADDR;
                        cnt <= '0;
                    end
                end
                FS_ADDR: begin
                    addr_sh <= addr_nx;
                    cnt     <= cnt + 5'd1;
                    if (cnt == alen - 5'd1) begin
                        cnt <= '0;
                        unique case (opcode_e'(op_sh))
                            OP_READ: begin
                                st      <= FS_STREAM;
                                reading <= 1'b1;
                                out_bit <= 1'b0;
                                rd_sh   <= rd_word;
                                rd_addr <= addr_nx;
                                rbit    <= '0;
                            end
                            OP_WRITE: begin
                                st        <= FS_DATA;
                                pend_kind <= PK_WRITE;
                            end
                            OP_ERASE: begin
                                st         <= FS_DONE;
                                pend_kind  <= PK_ERASE;
                                pend_valid <= 1'b1;
                            end
                            OP_SPECIAL: begin
                                unique case (sub)
                                    SUB_ENABLE:  begin wen_q <= 1'b1; st <= FS_DONE; end
                                    SUB_DISABLE: begin wen_q <= 1'b0; st <= FS_DONE; end
                                    SUB_ERASE_ALL: begin
                                        st         <= FS_DONE;
                                        pend_kind  <= PK_ERASE_ALL;
                                        pend_valid <= 1'b1;
                                    end
                                    SUB_WRITE_ALL: begin
                                        st        <= FS_DATA;
                                        pend_kind <= PK_WRITE_ALL;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
                FS_DATA: begin
                    data_sh <= {data_sh[14:0], di};
                    cnt     <= cnt + 5'd1;
                    if (cnt == dlen - 5'd1) begin
                        st         <= FS_DONE;
                        pend_valid <= 1'b1;
                    end
                end
                FS_STREAM: begin
                    out_bit <= rd_sh[15];
                    rd_sh   <= {rd_sh[14:0], 1'b0};
                    rbit    <= rbit + 5'd1;
                    if (rbit == dlen - 5'd1) begin
                        rbit    <= '0;
                        rd_addr <= rd_next;
                        rd_sh   <= rd_word;
                    end
                end
                default: ;
            endcase
        end
    end

    assign so_en   = cs & (reading | show_q);
    assign so_data = reading ? out_bit : ~busy;
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
    input logic clk,
    input logic rst,
    input logic cs,
    input logic prog_go,
    input logic busy,
    input logic wen_q,
    input logic reading,
    input logic out_bit
);
    // R6: a cycle never starts with the latch clear
    a_r6_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
        prog_go |-> wen_q);

    // R6: start only on the cycle chip select is seen falling
    a_r6_start_on_cs_fall: assert property (@(posedge clk) disable iff (rst)
        prog_go |-> (!cs && $past(cs)));

    // R6: the timer reports busy right after a start
    a_r6_busy_after_start: assert property (@(posedge clk) disable iff (rst)
        prog_go |=> busy);

    // R9: no second start while a cycle runs
    a_r9_no_start_while_busy: assert property (@(posedge clk) disable iff (rst)
        prog_go |-> !busy);

    // R3: latch is clear on the first cycle after reset
    a_r3_latch_clear_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !wen_q);

    // R4: a read stream opens with a zero
    a_r4_dummy_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(reading) |-> !out_bit);
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
    .clk(clk), .rst(rst), .cs(cs), .prog_go(prog_go), .busy(busy),
    .wen_q(wen_q), .reading(reading), .out_bit(out_bit)
);

// File: tb/tb_mw_eeprom.sv
module tb_mw_eeprom;
    localparam int PROG = 200;

    logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sk = 1'b0, di = 1'b0, org16 = 1'b1;
    logic so_data, so_en;

    mw_eeprom #(.WAW(6), .PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst(rst), .cs(cs), .sk(sk), .di(di), .org16(org16),
        .so_data(so_data), .so_en(so_en)
    );

    always #4 clk = ~clk;

    int    n_chk = 0, n_fail = 0;
    bit    running = 0, finished = 0;
    string cur_req = "R11";
    int    rd_buf[8];

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int mem[128];
    bit m_wen, m_show, m_reading, m_out, m_started, m_done, m_complete, m_need_data;
    bit q[$];
    int m_busy, m_raddr, m_rbit, m_kind, m_addr, m_data;
    bit m_sk_p, m_cs_p;

    function automatic int m_alen(); return org16 ? 6 : 7; endfunction
    function automatic int m_dlen(); return org16 ? 16 : 8; endfunction
    function automatic int m_words(); return org16 ? 64 : 128; endfunction

    function automatic int m_word(int a);
        if (org16) return (mem[2*a] << 8) | mem[2*a+1];
        return mem[a];
    endfunction

    task automatic m_store(int a, int d);
        if (org16) begin mem[2*a] = (d >> 8) & 255; mem[2*a+1] = d & 255; end
        else mem[a] = d & 255;
    endtask

    task automatic m_apply();
        case (m_kind)
            1: m_store(m_addr, m_data);
            2: m_store(m_addr, org16 ? 'hFFFF : 'hFF);
            3: for (int w = 0; w < m_words(); w++) m_store(w, m_data);
            4: for (int b = 0; b < 128; b++) mem[b] = 'hFF;
            default: ;
        endcase
    endtask

    function automatic int q_field(int from, int len);
        int v = 0;
        for (int k = 0; k < len; k++) v = (v << 1) | int'(q[from+k]);
        return v;
    endfunction

    task automatic m_bit(bit b);
        int n, op, sub;
        if (!m_started) begin
            if (b) begin m_started = 1; m_show = 0; q.delete(); end
        end else if (m_reading) begin
            m_out = m_word(m_raddr)[m_dlen()-1-m_rbit];
            m_rbit++;
            if (m_rbit == m_dlen()) begin
                m_rbit = 0;
                m_raddr = (m_raddr + 1) % m_words();
            end
        end else if (!m_done) begin
            q.push_back(b);
            n = q.size();
            if (n == 2 + m_alen()) begin
                op = q_field(0, 2);
                m_addr = q_field(2, m_alen());
                sub = q_field(2, 2);
                case (op)
                    2: begin m_reading = 1; m_out = 0; m_raddr = m_addr; m_rbit = 0; m_done = 1; end
                    1: begin m_kind = 1; m_need_data = 1; end
                    3: begin m_kind = 2; m_complete = 1; m_done = 1; end
                    default: case (sub)
                        3: begin m_wen = 1; m_done = 1; end
                        0: begin m_wen = 0; m_done = 1; end
                        2: begin m_kind = 4; m_complete = 1; m_done = 1; end
                        default: begin m_kind = 3; m_need_data = 1; end
                    endcase
                endcase
            end else if (m_need_data && n == 2 + m_alen() + m_dlen()) begin
                m_data = q_field(2 + m_alen(), m_dlen());
                m_complete = 1;
                m_done = 1;
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < 128; b++) mem[b] = 'hFF;
            m_wen = 0; m_show = 0; m_reading = 0; m_out = 0; m_started = 0;
            m_done = 0; m_complete = 0; m_need_data = 0; m_busy = 0; m_kind = 0;
            m_sk_p = 0; m_cs_p = 0; q.delete();
        end else begin
            bit skr, csf;
            int busy_now;
            skr = sk & !m_sk_p;
            csf = !cs & m_cs_p;
            busy_now = m_busy;
            if (m_busy > 0) m_busy--;
            if (!cs) begin
                if (csf && m_complete && m_wen && busy_now == 0) begin
                    m_apply();
                    m_busy = PROG;
                    m_show = 1;
                end
                q.delete();
                m_started = 0; m_reading = 0; m_done = 0;
                m_complete = 0; m_need_data = 0; m_kind = 0;
            end else if (skr && busy_now == 0) begin
                m_bit(di);
            end
            m_sk_p = sk;
            m_cs_p = cs;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (running && !rst) begin
            bit exp_en, exp_d;
            exp_en = cs & (m_reading | m_show);
            exp_d  = m_reading ? m_out : (m_busy == 0);
            n_chk++;
            if (so_en !== exp_en || (exp_en && so_data !== exp_d)) begin
                n_fail++;
                $display("FAIL %s cycle compare: got en=%b d=%b expected en=%b d=%b",
                         cur_req, so_en, so_data, exp_en, exp_d);
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sbit(bit b);
        @(negedge clk); sk = 0; di = b;
        @(negedge clk); sk = 1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic send(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) sbit(v[i]);
    endtask

    task automatic cs_on();
        @(negedge clk); cs = 1; sk = 0; di = 0;
    endtask

    task automatic cs_off();
        @(negedge clk); cs = 0; sk = 0; di = 0;
        tick(2);
    endtask

    function automatic int alen(); return org16 ? 6 : 7; endfunction
    function automatic int dlen(); return org16 ? 16 : 8; endfunction

    task automatic cmd_write(int a, int d);
        cs_on(); send(((32'(3'b101) << alen() | 32'(a)) << dlen()) | 32'(d), 3 + alen() + dlen()); cs_off();
    endtask

    task automatic cmd_erase(int a);
        cs_on(); send((32'(3'b111) << alen()) | 32'(a), 3 + alen()); cs_off();
    endtask

    task automatic cmd_special(int sub);
        cs_on(); send((32'(3'b100) << alen()) | (32'(sub) << (alen() - 2)), 3 + alen()); cs_off();
    endtask

    task automatic cmd_write_all(int d);
        cs_on();
        send((((32'(3'b100) << alen()) | (32'(1) << (alen() - 2))) << dlen()) | 32'(d),
             3 + alen() + dlen());
        cs_off();
    endtask

    task automatic read_seq(int a, int cnt, int lead_zeros);
        cs_on();
        for (int z = 0; z < lead_zeros; z++) sbit(0);
        send((32'(3'b110) << alen()) | 32'(a), 3 + alen());
        #1;
        check("R4", "dummy bit", so_data, 0);
        for (int w = 0; w < cnt; w++) begin
            int v = 0;
            for (int k = 0; k < dlen(); k++) begin
                sbit(0);
                #1;
                v = (v << 1) | int'(so_data);
            end
            rd_buf[w] = v;
        end
        cs_off();
    endtask

    task automatic wait_ready(string req);
        int n = 0;
        cs_on();
        @(negedge clk); #1;
        check(req, "busy status shown", {so_en, so_data}, 2'b10);
        while (so_data !== 1'b1 && n < 2000) begin
            @(negedge clk); #1;
            n++;
        end
        check(req, "ready status", {so_en, so_data}, 2'b11);
        cs_off();
    endtask

    task automatic expect_no_status(string req);
        cs_on();
        tick(2); #1;
        check(req, "no status after ignored command", so_en, 0);
        cs_off();
    endtask

    // ---------------- scenarios ----------------
    initial begin
        tick(4);
        rst = 0;
        running = 1;
        tick(2); #1;
        cur_req = "R11";
        check("R11", "output released after reset", so_en, 0);
        cur_req = "R7";
        expect_no_status("R7");

        cur_req = "R10";
        read_seq(5, 1, 0);
        check("R10", "erased word after reset", rd_buf[0], 'hFFFF);

        cur_req = "R3";
        cmd_write(5, 'h1234);
        expect_no_status("R3");
        read_seq(5, 1, 0);
        check("R3", "write with latch clear", rd_buf[0], 'hFFFF);

        cur_req = "R8";
        cmd_special(3);
        cmd_write(5, 'hA5C3);
        wait_ready("R7");
        read_seq(5, 1, 0);
        check("R8", "written word", rd_buf[0], 'hA5C3);

        cur_req = "R5";
        cmd_write(63, 'h1111); wait_ready("R6");
        cmd_write(0, 'h2222);  wait_ready("R6");
        read_seq(63, 3, 0);
        check("R5", "stream word at top", rd_buf[0], 'h1111);
        check("R5", "stream wraps to word 0", rd_buf[1], 'h2222);
        check("R5", "stream continues to word 1", rd_buf[2], 'hFFFF);

        cur_req = "R1";
        read_seq(5, 1, 3);
        check("R1", "leading zeros skipped", rd_buf[0], 'hA5C3);

        cur_req = "R8";
        cmd_erase(5); wait_ready("R8");
        read_seq(5, 1, 0);
        check("R8", "erased word", rd_buf[0], 'hFFFF);

        cur_req = "R6";
        cs_on(); send(((32'(3'b101) << 6) | 32'd7) << 10 | 32'h2AA, 19); cs_off();
        expect_no_status("R6");
        read_seq(7, 1, 0);
        check("R6", "short frame leaves word", rd_buf[0], 'hFFFF);

        cur_req = "R9";
        cmd_write(9, 'h0BAD);
        cmd_special(0);
        wait_ready("R9");
        cmd_write(10, 'h7777);
        wait_ready("R9");
        read_seq(9, 2, 0);
        check("R9", "first write kept", rd_buf[0], 'h0BAD);
        check("R9", "disable during busy ignored", rd_buf[1], 'h7777);

        cur_req = "R2";
        cmd_write_all('h0F0F); wait_ready("R2");
        read_seq(20, 1, 0);
        check("R2", "write-all", rd_buf[0], 'h0F0F);
        cmd_special(2); wait_ready("R2");
        read_seq(20, 1, 0);
        check("R2", "erase-all", rd_buf[0], 'hFFFF);

        cur_req = "R10";
        org16 = 0;
        tick(2);
        cmd_special(3);
        cmd_write(11, 'h3C); wait_ready("R10");
        cmd_write(10, 'h5A); wait_ready("R10");
        cmd_write(0, 'h81);  wait_ready("R10");
        read_seq(10, 2, 0);
        check("R10", "byte 10", rd_buf[0], 'h5A);
        check("R10", "byte 11", rd_buf[1], 'h3C);
        org16 = 1;
        tick(2);
        read_seq(5, 1, 0);
        check("R10", "word 5 from bytes 10 and 11", rd_buf[0], 'h5A3C);
        org16 = 0;
        tick(2);
        cur_req = "R5";
        read_seq(127, 2, 0);
        check("R5", "byte 127", rd_buf[0], 'hFF);
        check("R5", "byte stream wraps to 0", rd_buf[1], 'h81);

        cur_req = "R3";
        cmd_special(0);
        cmd_write(3, 'h00);
        expect_no_status("R3");
        read_seq(3, 1, 0);
        check("R3", "write after disable", rd_buf[0], 'hFF);

        running = 0;
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL %s watchdog: got timeout expected completion", cur_req);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule